// File: doc/BRIEF.md
# Manchester Line Encoder and Decoder

This block is the bit-level line coding stage of a 10 Mb/s twisted-pair port. Both halves run from one clock at `OSR` times the bit rate (8x, 80 MHz, by default). The transmit half turns a serial NRZ bit stream into Manchester cells. It asks for each new bit with a one-cycle strobe and drives a line level together with a drive-enable. When the enable is low, the line is undriven, which is the idle state.

The receive half takes a line that has already been sampled and synchronised to the same clock. It locks the cell phase to the mid-cell transitions and emits one recovered NRZ bit per cell with a valid strobe. It holds a receive-active flag for as long as mid-cell transitions keep arriving. Clock recovery is done by counting samples, without an analog loop. For this reason a frame must begin with a 1 bit, as a preamble does.

When the encoder's output is looped into the decoder, the bits put into the transmit side come back out of the receive side in the same order.

Top module: `manch_codec`

## Requirements
- R1: Out of reset, `line_en`, `line_out`, `tx_strobe`, `rx_valid` and `rx_active` are all 0. A rise of `tx_en` while `link_ok` is 1 and the encoder is idle makes `tx_strobe` pulse at once, and `line_en` is 1 from the next clock.
- R2: Each bit occupies OSR cycles on `line_out`. A 1 is low for the first OSR/2 cycles and high for the last OSR/2 cycles; a 0 is the reverse. The level always changes at mid-cell.
- R3: `tx_strobe` marks the cycle in which `tx_data` is captured. Inside a frame, successive strobes are exactly OSR cycles apart.
- R4: If `tx_en` is 0 at a cell boundary, the encoder drives `line_out` high for TAIL_BITS*OSR cycles and then drops `line_en`. So after a final 1 the last transition is at the centre of the cell, and after a final 0 it is the low-to-high step at the cell boundary.
- R5: If `link_ok` is 0 at a cell boundary, `line_en` drops at that boundary with no tail, so only whole cells are sent.
- R6: A new frame starts only on a fresh rise of `tx_en`. If `tx_en` is held high across a link loss, no strobe and no line activity follow when `link_ok` returns.
- R7: While the receiver is inactive, a low-to-high step on `line_in` sets `rx_active` and yields a 1 bit (`rx_valid` with `rx_data`=1) in the next cycle. A high-to-low step while inactive is ignored.
- R8: While active, a `line_in` transition at least OSR/2+2 samples after the last accepted one is a mid-cell transition. `rx_data` then takes the new line level, and `rx_valid` pulses for one cycle. Earlier transitions (cell boundaries) are ignored.
- R9: `rx_active` falls exactly OSR+OSR/2 cycles (1.5 bit times) after the `rx_valid` pulse of the last bit, once no mid-cell transition has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OSR times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; a rise starts a frame |
| tx_data | input | 1 | Next NRZ bit, captured when `tx_strobe` is high |
| link_ok | input | 1 | Link-good; low ends transmission at the next cell boundary |
| tx_strobe | output | 1 | One-cycle bit request / capture marker |
| line_out | output | 1 | Manchester line level |
| line_en | output | 1 | Line drive enable; low means idle |
| line_in | input | 1 | Sampled, synchronised receive line |
| rx_data | output | 1 | Recovered NRZ bit |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_active | output | 1 | Receive carrier flag |

## Verification
The bench loops the encoder into the decoder and sends frames ending in 1 and in 0, a single-bit frame and a long mixed frame. A design that put the final transition in the wrong place, or that dropped the tail, shows up as a mismatch against the cell-by-cell line waveform built in the bench. The boundary transitions that runs of equal bits create must be ignored: a decoder with a mis-set acceptance window would emit extra or inverted bits into the scoreboard. A link loss during a frame with `tx_en` held high checks that the line stops on a whole cell and does not restart. A receiver that released carrier early or late, or that started on a falling step or a lone glitch, would break the exact 12-cycle release check or the bit count.

// File: rtl/manch_pkg.sv
package manch_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_TAIL = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic en;
        logic lvl;
    } line_sym_t;

    typedef struct packed {
        logic active;
        logic valid;
        logic data;
    } rx_flags_t;

    // Level of a Manchester cell half: first half carries the complement.
    function automatic logic cell_level(input logic bitv, input logic second_half);
        return second_half ? bitv : ~bitv;
    endfunction

endpackage

// File: rtl/manch_tx_enc.sv
module manch_tx_enc
    import manch_pkg::*;
#(
    parameter int OSR       = 8,
    parameter int TAIL_BITS = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tx_en,
    input  logic      tx_data,
    input  logic      link_ok,
    output logic      tx_strobe,
    output line_sym_t sym
);
    localparam int HALF     = OSR / 2;
    localparam int PH_W     = $clog2(OSR);
    localparam int TAIL_LEN = TAIL_BITS * OSR;
    localparam int TL_W     = $clog2(TAIL_LEN + 1);

    tx_state_e        st;
    logic [PH_W-1:0]  ph;
    logic [TL_W-1:0]  tail_cnt;
    logic             bit_q;
    logic             armed;
    logic             cell_end;
    logic             take;

    assign cell_end  = (st == TX_SEND) && (ph == PH_W'(OSR - 1));
    assign take      = link_ok && tx_en && (((st == TX_IDLE) && armed) || cell_end);
    assign tx_strobe = take;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= TX_IDLE;
            ph       <= '0;
            tail_cnt <= '0;
            bit_q    <= 1'b0;
            armed    <= 1'b0;
        end else begin
            armed <= ~tx_en;
            case (st)
                TX_IDLE: begin
                    if (take) begin
                        st    <= TX_SEND;
                        ph    <= '0;
                        bit_q <= tx_data;
                    end
                end
                TX_SEND: begin
                    if (cell_end) begin
                        if (take) begin
                            bit_q <= tx_data;
                            ph    <= '0;
                        end else if (!link_ok) begin
                            st <= TX_IDLE;
                        end else begin
                            st       <= TX_TAIL;
                            tail_cnt <= '0;
                        end
                    end else begin
                        ph <= ph + PH_W'(1);
                    end
                end
                TX_TAIL: begin
                    if (tail_cnt == TL_W'(TAIL_LEN - 1)) st <= TX_IDLE;
                    else tail_cnt <= tail_cnt + TL_W'(1);
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        sym = '{en: 1'b0, lvl: 1'b0};
        case (st)
            TX_SEND: sym = '{en: 1'b1, lvl: cell_level(bit_q, ph >= PH_W'(HALF))};
            TX_TAIL: sym = '{en: 1'b1, lvl: 1'b1};
            default: sym = '{en: 1'b0, lvl: 1'b0};
        endcase
    end

    // R1: a granted start puts the line into drive on the next clock
    p_start_drive_r1: assert property (@(posedge clk) disable iff (rst)
        (st == TX_IDLE && take) |=> sym.en);

    // R2: the level flips at every mid-cell point
    p_mid_flip_r2: assert property (@(posedge clk) disable iff (rst)
        (st == TX_SEND && ph == PH_W'(HALF)) |-> (sym.lvl != $past(sym.lvl)));

    // R3: bit requests are never back to back
    p_strobe_gap_r3: assert property (@(posedge clk) disable iff (rst)
        tx_strobe |=> !tx_strobe);

    // R4: the closing tail is driven high
    p_tail_high_r4: assert property (@(posedge clk) disable iff (rst)
        (st == TX_TAIL) |-> (sym.en && sym.lvl));

    // R5: link loss at a boundary releases the line at once
    p_link_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (cell_end && !link_ok) |=> !sym.en);

    // R6: the line only comes up after tx_en was seen low
    p_fresh_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sym.en) |-> $past(armed));

endmodule

// File: rtl/manch_rx_dec.sv
module manch_rx_dec
    import manch_pkg::*;
#(
    parameter int OSR = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      line_in,
    output rx_flags_t flags
);
    localparam int HALF    = OSR / 2;
    localparam int EOF_LIM = OSR + HALF;
    localparam int WIN_LO  = HALF + 2;
    localparam int PH_W    = $clog2(EOF_LIM + 1);

    logic            q;
    logic            act;
    logic            valid;
    logic            data;
    logic [PH_W-1:0] ph;
    logic            edge_seen;
    logic            rise_seen;
    logic            in_window;

    assign edge_seen = line_in ^ q;
    assign rise_seen = line_in & ~q;
    assign in_window = ph >= PH_W'(WIN_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= 1'b0;
            act   <= 1'b0;
            valid <= 1'b0;
            data  <= 1'b0;
            ph    <= '0;
        end else begin
            q     <= line_in;
            valid <= 1'b0;
            if (!act) begin
                if (rise_seen) begin
                    act   <= 1'b1;
                    valid <= 1'b1;
                    data  <= 1'b1;
                    ph    <= PH_W'(1);
                end
            end else if (edge_seen && in_window) begin
                valid <= 1'b1;
                data  <= line_in;
                ph    <= PH_W'(1);
            end else if (ph == PH_W'(EOF_LIM)) begin
                act <= 1'b0;
            end else begin
                ph <= ph + PH_W'(1);
            end
        end
    end

    assign flags = '{active: act, valid: valid, data: data};

    // R7: a rising step on an idle line locks and yields a 1
    p_lock_rise_r7: assert property (@(posedge clk) disable iff (rst)
        (!act && rise_seen) |=> (act && valid && data));

    // R8: recovered bits only appear inside a frame
    p_valid_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
        valid |-> act);

    // R9: carrier never drops right after a bit was delivered
    p_quiet_release_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(act) |-> !$past(valid));

endmodule

// File: rtl/manch_codec.sv
module manch_codec
    import manch_pkg::*;
#(
    parameter int OSR       = 8,
    parameter int TAIL_BITS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic tx_data,
    input  logic link_ok,
    output logic tx_strobe,
    output logic line_out,
    output logic line_en,
    input  logic line_in,
    output logic rx_data,
    output logic rx_valid,
    output logic rx_active
);
    line_sym_t tx_sym;
    rx_flags_t rx_flags;

    manch_tx_enc #(.OSR(OSR), .TAIL_BITS(TAIL_BITS)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .tx_data   (tx_data),
        .link_ok   (link_ok),
        .tx_strobe (tx_strobe),
        .sym       (tx_sym)
    );

    manch_rx_dec #(.OSR(OSR)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_in),
        .flags   (rx_flags)
    );

    assign line_out  = tx_sym.lvl;
    assign line_en   = tx_sym.en;
    assign rx_data   = rx_flags.data;
    assign rx_valid  = rx_flags.valid;
    assign rx_active = rx_flags.active;

endmodule

// File: tb/manch_codec_bench.sv
module manch_codec_bench;
    localparam int OSR       = 8;
    localparam int TAIL_BITS = 2;
    localparam int REL       = OSR + OSR / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic tx_en = 1'b0, tx_data = 1'b0, link_ok = 1'b1;
    logic tx_strobe, line_out, line_en, line_in, rx_data, rx_valid, rx_active;
    logic man_sel = 1'b0, man_lvl = 1'b0;

    assign line_in = man_sel ? man_lvl : (line_en & line_out);

    manch_codec #(.OSR(OSR), .TAIL_BITS(TAIL_BITS)) u_manch_codec (
        .clk(clk), .rst(rst), .tx_en(tx_en), .tx_data(tx_data), .link_ok(link_ok),
        .tx_strobe(tx_strobe), .line_out(line_out), .line_en(line_en), .line_in(line_in),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_active(rx_active)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_v = -1000;
    int last_stb = -1000;
    logic prev_act = 1'b0;
    logic rec = 1'b0;
    logic exp_q[$];
    logic [1:0] wave[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: scoreboard pop, carrier release timing, strobe spacing, waveform capture
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (rx_valid) begin
                if (exp_q.size() == 0) chk(0, "R8 unexpected bit", rx_data, -1);
                else begin
                    logic e;
                    e = exp_q.pop_front();
                    chk(rx_data == e, "R8 decoded bit", rx_data, e);
                end
                last_v = cyc;
            end
            if (prev_act && !rx_active) chk(cyc - last_v == REL, "R9 carrier release", cyc - last_v, REL);
            prev_act = rx_active;
            if (tx_strobe) begin
                if (cyc - last_stb < 3 * OSR) chk(cyc - last_stb == OSR, "R3 strobe spacing", cyc - last_stb, OSR);
                last_stb = cyc;
            end
            if (rec) wave.push_back({line_en, line_out});
        end
    end

    task automatic check_wave(input logic [63:0] pat, input int n);
        int s = -1;
        int mism = 0;
        int len;
        logic [1:0] ex;
        len = n * OSR + TAIL_BITS * OSR + 1;
        for (int i = 0; i < wave.size(); i++) if (s < 0 && wave[i][1]) s = i;
        chk(s >= 0, "R1 line came up", s, 0);
        if (s < 0) return;
        for (int k = 0; k < len; k++) begin
            if (k < n * OSR) ex = {1'b1, ((k % OSR) < OSR / 2) ? ~pat[k / OSR] : pat[k / OSR]};
            else if (k < len - 1) ex = 2'b11;
            else ex = 2'b00;
            if (s + k >= wave.size() || wave[s + k] != ex) mism++;
        end
        chk(mism == 0, "R2 line waveform", mism, 0);
        if (s + n * OSR < wave.size()) begin
            if (pat[n - 1]) chk(wave[s + n*OSR - 1] == 2'b11 && wave[s + n*OSR] == 2'b11,
                                "R4 final 1 ends at centre", int'(wave[s + n*OSR - 1]), 3);
            else chk(wave[s + n*OSR - 1] == 2'b10 && wave[s + n*OSR] == 2'b11,
                     "R4 final 0 steps at boundary", int'(wave[s + n*OSR - 1]), 2);
        end
    endtask

    // Driver: feeds bits on each strobe and pushes them into the expected queue
    task automatic send(input logic [63:0] pat, input int n);
        wave.delete();
        rec = 1'b1;
        tx_data = pat[0];
        tx_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            tx_data = pat[i];
            @(negedge clk);
            while (!tx_strobe) @(negedge clk);
            exp_q.push_back(pat[i]);
            @(posedge clk); #1;
        end
        tx_en = 1'b0;
        repeat (OSR + TAIL_BITS * OSR + 3 * OSR) @(posedge clk);
        #1;
        rec = 1'b0;
        check_wave(pat, n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] lpat;
        int hi_cnt;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk({line_en, line_out, tx_strobe, rx_valid, rx_active} == 5'b0, "R1 reset idle",
            int'({line_en, line_out, tx_strobe, rx_valid, rx_active}), 0);
        @(posedge clk); #1;

        send(64'b1101_0101, 8);            // ends in 1
        send(64'b0001_0011, 8);            // ends in 0
        lpat = 64'h1;
        for (int i = 1; i < 40; i++) lpat[i] = lpat[i-1] ^ lpat[(i*7) % i] ^ (i % 3 == 0);
        send(lpat, 40);                    // long mixed frame
        send(64'b1, 1);                    // single bit

        // Link loss mid-frame with tx_en held high
        wave.delete();
        rec = 1'b1;
        tx_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tx_data = (i != 1);
            @(negedge clk);
            while (!tx_strobe) @(negedge clk);
            exp_q.push_back(i != 1);
            @(posedge clk); #1;
        end
        repeat (3) @(posedge clk);
        #1 link_ok = 1'b0;
        repeat (30) @(posedge clk);
        #1 rec = 1'b0;
        hi_cnt = 0;
        foreach (wave[i]) if (wave[i][1]) hi_cnt++;
        chk(hi_cnt == 3 * OSR, "R5 whole cells only", hi_cnt, 3 * OSR);
        link_ok = 1'b1;
        hi_cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (line_en || tx_strobe) hi_cnt++;
        end
        chk(hi_cnt == 0, "R6 no restart without new rise", hi_cnt, 0);
        @(posedge clk); #1 tx_en = 1'b0;
        repeat (30) @(posedge clk);
        #1;

        // Direct receive stimulus
        man_lvl = 1'b0;
        man_sel = 1'b1;
        repeat (5) @(posedge clk);
        #1 man_lvl = 1'b1;
        exp_q.push_back(1'b1);
        @(posedge clk);
        @(negedge clk);
        chk(rx_active == 1'b1, "R7 lock on rising step", rx_active, 1);
        repeat (30) @(posedge clk);
        #1 man_lvl = 1'b0;                 // falling while inactive
        repeat (20) @(negedge clk);
        chk(rx_active == 1'b0, "R7 falling step ignored", rx_active, 0);
        @(posedge clk); #1 man_lvl = 1'b1;  // short glitch
        exp_q.push_back(1'b1);
        repeat (2) @(posedge clk);
        #1 man_lvl = 1'b0;
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(rx_active == 1'b0, "R9 glitch released", rx_active, 0);
        chk(exp_q.size() == 0, "R8 all bits decoded", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule